// File: doc/BRIEF.md
# Serial-Bus Peripheral Control and Interrupt Register Block

This block is the memory-mapped register front end of a serial-bus controller. A simple 32-bit register bus with separate read and write strobes reaches two control words. Each of them can be written directly, through a set alias that ORs the written bits into the word, or through a clear alias that removes the written bits from it. Because of the aliases, software can change single bits without a read-modify-write sequence. A third address returns a read-only status word that the bus engine supplies.

The interrupt word holds eight sticky status bits in bits 7:0, and each bit's enable sits eight positions higher, in bits 15:8. One-cycle event pulses from the engine set the status bits. A single registered interrupt line is raised while any enabled status bit is set. The main control word exports its fields to the engine. Its top bit is a soft reset that holds the rest of the block at its reset values. A write-one command bit in the interrupt word sends a one-cycle pulse to the engine, which tells it to drop a latched missing-acknowledge condition and return to idle.

Top module: `sbus_regblk`

## Requirements
- R1: After reset every register reads zero, `ctrl_o`, `soft_rst_o`, `irq_o` and `nak_clr_o` are low, and `bus_rdata` is zero. Read data is registered: it appears on `bus_rdata` one clock after the edge that samples `bus_rd`, and it holds until the next read.
- R2: A write to 0x00 (main control) or to 0x40 (interrupt word) replaces the stored bits with the written value. Main control bit 31 drives `soft_rst_o` and bits 30:0 drive `ctrl_o`. In the interrupt word, bits 7:0 are status, bits 15:8 are enable, and every other bit reads zero.
- R3: A write to base+4 (0x04 or 0x44) ORs the written bits into that register.
- R4: A write to base+8 (0x08 or 0x48) clears the register bits that are set in the written value.
- R5: A high pulse on `evt_i[i]` sets interrupt status bit i, and the bit stays set until software clears it. When an event and a software clear or write of the same bit fall in one cycle, the event wins. The status bits are: 0 slave addressed, 1 slave stop, 2 arbitration lost, 3 early termination, 4 oversize transfer, 5 no acknowledge, 6 data engine done, 7 bus free.
- R6: `irq_o` is a register. It is high in the cycle after the interrupt word holds some bit i with both status bit i and enable bit i+8 set.
- R7: Writing a one to bit 28 at 0x40 or 0x44 makes `nak_clr_o` high for exactly the following cycle. Bit 28 is never stored and reads zero, and a one in bit 28 written to 0x48 gives no pulse.
- R8: A read of 0x50 returns `eng_stat_i` as it was at the read edge. A write to 0x50 changes no register.
- R9: Any address other than 0x00, 0x04, 0x08, 0x40, 0x44, 0x48 and 0x50 reads zero, and a write to such an address changes no register.
- R10: From the edge at which main control bit 31 becomes 1, and for as long as it stays 1: control bits 30:0 and the whole interrupt word are zero, writes to them and events are discarded, `irq_o` and `nak_clr_o` stay low, and bit 31 can still be written, set or cleared through its aliases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | 8 | One-cycle event pulses from the bus engine |
| eng_stat_i | input | 32 | Live status word from the bus engine |
| ctrl_o | output | 31 | Main control bits 30:0 |
| soft_rst_o | output | 1 | Soft reset (main control bit 31) |
| irq_o | output | 1 | Combined registered interrupt |
| nak_clr_o | output | 1 | One-cycle command to drop a latched missing-acknowledge condition |

## Verification
Register contents, `ctrl_o` and `soft_rst_o` change at the edge that samples the write or the event. `nak_clr_o` follows at that same edge, and `irq_o` follows one edge later. Read data is due one edge after the read strobe. The bench drives inputs on the falling edge and samples on the next falling edge, so each check falls inside the cycle its result is due. The `irq_o` latency is also checked in a directed case, where the line must still be low half a cycle after the enabling write and must be high one cycle later. The reference model advances only at the edges where the design samples its inputs.

// File: rtl/sbus_regblk_pkg.sv
package sbus_regblk_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } alias_op_e;

  localparam int unsigned CTRL_BASE  = 32'h00;
  localparam int unsigned IRQ_BASE   = 32'h40;
  localparam int unsigned STAT_ADDR  = 32'h50;
  localparam int unsigned SET_OFS    = 4;
  localparam int unsigned CLR_OFS    = 8;
  localparam int unsigned SRST_BIT   = 31;
  localparam int unsigned NAKCLR_BIT = 28;

endpackage

// File: rtl/sbus_alias_dec.sv
module sbus_alias_dec
  import sbus_regblk_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned BASE = 0
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output alias_op_e     op_o
);

  localparam logic [AW-1:0] A_WR  = AW'(BASE);
  localparam logic [AW-1:0] A_SET = AW'(BASE + SET_OFS);
  localparam logic [AW-1:0] A_CLR = AW'(BASE + CLR_OFS);

  always_comb begin
    op_o = OP_NONE;
    if (wr_i) begin
      if (addr_i == A_WR)       op_o = OP_WR;
      else if (addr_i == A_SET) op_o = OP_SET;
      else if (addr_i == A_CLR) op_o = OP_CLR;
    end
  end

endmodule

// File: rtl/sbus_alias_reg.sv
module sbus_alias_reg
  import sbus_regblk_pkg::*;
#(
  parameter int unsigned   W   = 8,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  input  logic         sync_clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] sw_d;
  logic         en;

  always_comb begin
    unique case (op_i)
      OP_WR:   sw_d = wdata_i;
      OP_SET:  sw_d = q_r | wdata_i;
      OP_CLR:  sw_d = q_r & ~wdata_i;
      default: sw_d = q_r;
    endcase
    d_o = sync_clr_i ? RST : (sw_d | set_i);
    en  = sync_clr_i | (op_i != OP_NONE) | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST;
    else if (en) q_r <= d_o;
  end

  assign q_o = q_r;

  p_direct_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_WR && !sync_clr_i) |=> (q_o == ($past(wdata_i) | $past(set_i))));

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SET && !sync_clr_i) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));

  p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLR && !sync_clr_i) |=> ((q_o & $past(wdata_i) & ~$past(set_i)) == '0));

  p_sync_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_i |=> (q_o == RST));

endmodule

// File: rtl/sbus_irq_ctl.sv
module sbus_irq_ctl
  import sbus_regblk_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  alias_op_e      op_i,
  input  logic [2*N-1:0] wdata_i,
  input  logic           nak_cmd_i,
  input  logic [N-1:0]   evt_i,
  input  logic           hold_i,
  output logic [N-1:0]   stat_o,
  output logic [N-1:0]   en_o,
  output logic           irq_o,
  output logic           nak_clr_o
);

  logic [N-1:0] evt_g;
  logic [N-1:0] stat_d_unused;
  logic [N-1:0] en_d_unused;
  logic         irq_q, irq_d;
  logic         nak_q, nak_d;

  assign evt_g = evt_i & ~{N{hold_i}};

  sbus_alias_reg #(.W(N), .RST('0)) u_stat (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .wdata_i(wdata_i[N-1:0]),
    .set_i(evt_g), .sync_clr_i(hold_i), .q_o(stat_o), .d_o(stat_d_unused)
  );

  sbus_alias_reg #(.W(N), .RST('0)) u_en (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .wdata_i(wdata_i[2*N-1:N]),
    .set_i('0), .sync_clr_i(hold_i), .q_o(en_o), .d_o(en_d_unused)
  );

  always_comb begin
    irq_d = !hold_i && (|(stat_o & en_o));
    nak_d = !hold_i && nak_cmd_i && (op_i == OP_WR || op_i == OP_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nak_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nak_q <= nak_d;
    end
  end

  assign irq_o     = irq_q;
  assign nak_clr_o = nak_q;

  p_evt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!irq_o && !nak_clr_o));

  p_irq_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && (|(stat_o & en_o))) |=> irq_o);

endmodule

// File: rtl/sbus_regblk.sv
module sbus_regblk
  import sbus_regblk_pkg::*;
#(
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NIRQ-1:0] evt_i,
  input  logic [DW-1:0]   eng_stat_i,
  output logic [DW-2:0]   ctrl_o,
  output logic            soft_rst_o,
  output logic            irq_o,
  output logic            nak_clr_o
);

  localparam int unsigned PADW = DW - 2*NIRQ;
  localparam logic [AW-1:0] A_CW = AW'(CTRL_BASE);
  localparam logic [AW-1:0] A_CS = AW'(CTRL_BASE + SET_OFS);
  localparam logic [AW-1:0] A_CC = AW'(CTRL_BASE + CLR_OFS);
  localparam logic [AW-1:0] A_IW = AW'(IRQ_BASE);
  localparam logic [AW-1:0] A_IS = AW'(IRQ_BASE + SET_OFS);
  localparam logic [AW-1:0] A_IC = AW'(IRQ_BASE + CLR_OFS);
  localparam logic [AW-1:0] A_ST = AW'(STAT_ADDR);

  alias_op_e       op_ctrl, op_irq;
  logic            srst_q, srst_d;
  logic [DW-2:0]   ctrl_q, ctrl_d_unused;
  logic [NIRQ-1:0] stat_q, en_q;
  logic [DW-1:0]   irq_word;
  logic [DW-1:0]   rdata_q, rdata_d;

  sbus_alias_dec #(.AW(AW), .BASE(CTRL_BASE)) u_dec_ctrl (
    .wr_i(bus_wr), .addr_i(bus_addr), .op_o(op_ctrl)
  );

  sbus_alias_dec #(.AW(AW), .BASE(IRQ_BASE)) u_dec_irq (
    .wr_i(bus_wr), .addr_i(bus_addr), .op_o(op_irq)
  );

  sbus_alias_reg #(.W(1), .RST(1'b0)) u_srst (
    .clk(clk), .rst_n(rst_n), .op_i(op_ctrl), .wdata_i(bus_wdata[SRST_BIT]),
    .set_i(1'b0), .sync_clr_i(1'b0), .q_o(srst_q), .d_o(srst_d)
  );

  sbus_alias_reg #(.W(DW-1), .RST('0)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_i(op_ctrl), .wdata_i(bus_wdata[DW-2:0]),
    .set_i('0), .sync_clr_i(srst_d), .q_o(ctrl_q), .d_o(ctrl_d_unused)
  );

  sbus_irq_ctl #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .op_i(op_irq), .wdata_i(bus_wdata[2*NIRQ-1:0]),
    .nak_cmd_i(bus_wdata[NAKCLR_BIT]), .evt_i(evt_i), .hold_i(srst_d),
    .stat_o(stat_q), .en_o(en_q), .irq_o(irq_o), .nak_clr_o(nak_clr_o)
  );

  assign irq_word = {{PADW{1'b0}}, en_q, stat_q};

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      if (bus_addr == A_CW || bus_addr == A_CS || bus_addr == A_CC)
        rdata_d = {srst_q, ctrl_q};
      else if (bus_addr == A_IW || bus_addr == A_IS || bus_addr == A_IC)
        rdata_d = irq_word;
      else if (bus_addr == A_ST)
        rdata_d = eng_stat_i;
      else
        rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata  = rdata_q;
  assign ctrl_o     = ctrl_q;
  assign soft_rst_o = srst_q;

  p_srst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (ctrl_o == '0 && !irq_o));

  p_nak_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IW && bus_wdata[NAKCLR_BIT] && !soft_rst_o) |=> nak_clr_o);

  p_stat_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_ST) |=> (bus_rdata == $past(eng_stat_i)));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != A_CW && bus_addr != A_CS && bus_addr != A_CC &&
     bus_addr != A_IW && bus_addr != A_IS && bus_addr != A_IC && bus_addr != A_ST)
    |=> (bus_rdata == '0));

endmodule

// File: tb/tb_sbus_regblk.sv
module tb_sbus_regblk;

  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  evt_i;
  logic [31:0] eng_stat_i;
  logic [30:0] ctrl_o;
  logic        soft_rst_o, irq_o, nak_clr_o;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  // model state
  logic        m_srst;
  logic [30:0] m_ctrl;
  logic [7:0]  m_stat, m_en;
  logic        m_nak;

  sbus_regblk dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .eng_stat_i(eng_stat_i), .ctrl_o(ctrl_o),
    .soft_rst_o(soft_rst_o), .irq_o(irq_o), .nak_clr_o(nak_clr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] apply_op(input logic [31:0] q, input logic [1:0] op,
                                           input logic [31:0] d);
    case (op)
      2'd1:    return d;
      2'd2:    return q | d;
      2'd3:    return q & ~d;
      default: return q;
    endcase
  endfunction

  // op code for an address relative to a base: 0 none, 1 write, 2 set, 3 clear
  function automatic logic [1:0] op_of(input logic [7:0] a, input logic [7:0] base);
    if (a == base)      return 2'd1;
    if (a == base + 4)  return 2'd2;
    if (a == base + 8)  return 2'd3;
    return 2'd0;
  endfunction

  function automatic void model_step(input logic [7:0] a, input logic [31:0] d,
                                     input logic [7:0] ev);
    logic [1:0]  oc, oi;
    logic [31:0] c, s, e;
    oc = op_of(a, 8'h00);
    oi = op_of(a, 8'h40);
    c  = apply_op({m_srst, m_ctrl}, oc, d);
    m_srst = c[31];
    if (m_srst) begin
      m_ctrl = '0; m_stat = '0; m_en = '0; m_nak = 1'b0;
    end else begin
      m_ctrl = c[30:0];
      s = apply_op({24'd0, m_stat}, oi, {24'd0, d[7:0]});
      e = apply_op({24'd0, m_en},   oi, {24'd0, d[15:8]});
      m_stat = s[7:0] | ev;
      m_en   = e[7:0];
      m_nak  = (oi == 2'd1 || oi == 2'd2) && d[28];
    end
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04 || a == 8'h08) return {m_srst, m_ctrl};
    if (a == 8'h40 || a == 8'h44 || a == 8'h48) return {16'd0, m_en, m_stat};
    if (a == 8'h50) return eng_stat_i;
    return 32'd0;
  endfunction

  function automatic logic exp_irq();
    return !m_srst && (|(m_stat & m_en));
  endfunction

  // one bus write with optional events; nak_clr_o checked at the next falling edge
  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev,
                          input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(posedge clk);
    model_step(a, d, ev);
    @(negedge clk);
    bus_wr = 1'b0; evt_i = '0;
    check({tag, " R7 nak pulse"}, {31'd0, nak_clr_o}, {31'd0, m_nak});
    check({tag, " R2 ctrl_o"}, {1'b0, ctrl_o}, {1'b0, m_ctrl});
    check({tag, " R10 soft_rst_o"}, {31'd0, soft_rst_o}, {31'd0, m_srst});
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp_read(a));
    check({tag, " R6 irq"}, {31'd0, irq_o}, {31'd0, exp_irq()});
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 10)
      0: return 8'h00;
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h40;
      4: return 8'h44;
      5: return 8'h48;
      6: return 8'h50;
      7: return 8'h3C;
      8: return 8'h44;
      default: return 8'h48;
    endcase
  endfunction

  initial begin
    logic [31:0] seed_dummy;
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    seed_dummy = $urandom(32'd1234);
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; evt_i = 0;
    eng_stat_i = 32'h1234_0C00;
    m_srst = 0; m_ctrl = 0; m_stat = 0; m_en = 0; m_nak = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 rdata after reset", bus_rdata, 32'd0);
    check("R1 ctrl_o after reset", {1'b0, ctrl_o}, 32'd0);
    check("R1 flags after reset", {29'd0, soft_rst_o, irq_o, nak_clr_o}, 32'd0);
    do_read(8'h00, "R1 ctrl reads zero");
    do_read(8'h40, "R1 irq word reads zero");

    // R2 / R3 / R4 on main control
    do_write(8'h00, 32'h1234_5678, 8'h00, "R2 direct");
    do_read(8'h00, "R2 ctrl direct write");
    do_write(8'h04, 32'h4000_0001, 8'h00, "R3 set");
    do_read(8'h04, "R3 ctrl set alias");
    do_write(8'h08, 32'h0000_0678, 8'h00, "R4 clr");
    do_read(8'h08, "R4 ctrl clear alias");

    // R6 latency: enable + event in one write, irq low half a cycle later, high one cycle later
    do_write(8'h44, 32'h0000_0100, 8'h01, "R6 setup");
    check("R6 irq not yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R6 irq one cycle later", {31'd0, irq_o}, 32'd1);

    // R5: event wins over same-cycle clear
    do_write(8'h48, 32'h0000_00FF, 8'h05, "R5 evt vs clr");
    do_read(8'h40, "R5 event beats clear");
    do_write(8'h40, 32'h0000_FF00, 8'h80, "R5 evt vs wr");
    do_read(8'h40, "R5 event beats direct write");

    // R7: nak command via write and set, not clear; bit 28 reads zero
    do_write(8'h44, 32'h1000_0000, 8'h00, "R7 set alias");
    do_write(8'h48, 32'h1000_0000, 8'h00, "R7 clr alias no pulse");
    do_write(8'h40, 32'h1000_0000, 8'h00, "R7 direct");
    do_read(8'h40, "R7 bit28 reads zero");

    // R8 / R9: status reads, ignored writes
    do_write(8'h00, 32'h0000_00AA, 8'h00, "R9 prep");
    do_write(8'h44, 32'h0000_0303, 8'h00, "R9 prep irq");
    do_write(8'h50, 32'hFFFF_FFFF, 8'h00, "R8 write status");
    do_read(8'h00, "R8 ctrl unchanged after status write");
    do_read(8'h40, "R8 irq unchanged after status write");
    do_read(8'h50, "R8 status read");
    do_write(8'h3C, 32'hFFFF_FFFF, 8'h00, "R9 unmapped write");
    do_read(8'h00, "R9 ctrl unchanged after unmapped write");
    do_read(8'h40, "R9 irq unchanged after unmapped write");
    do_read(8'hFC, "R9 unmapped read");

    // R10: soft reset
    do_write(8'h04, 32'h8000_0000, 8'h00, "R10 assert");
    do_read(8'h40, "R10 irq word cleared");
    do_write(8'h44, 32'h1000_FFFF, 8'hFF, "R10 ignored write");
    do_read(8'h40, "R10 irq stays clear");
    do_write(8'h00, 32'h8000_FFFF, 8'h00, "R10 ctrl held");
    do_read(8'h00, "R10 ctrl low bits zero");
    do_write(8'h08, 32'h8000_0000, 8'h00, "R10 release");
    do_read(8'h00, "R10 released");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [7:0]  ev;
      a  = pick_addr($urandom);
      d  = $urandom;
      ev = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      if ((a == 8'h00 || a == 8'h04) && ($urandom % 6) != 0) d[31] = 1'b0;
      if (i % 50 == 0) eng_stat_i = $urandom;
      do_write(a, d, ev, "R3 R4 R5 random");
      do_read(8'h00, "R2 R3 R4 random ctrl");
      do_read(8'h40, "R2 R5 random irq");
      do_read(pick_addr($urandom), "R8 R9 random other");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule